// File: doc/BRIEF.md
# Stimulus Source Select and Prescaler

This block picks the data signal that a flip-flop metastability experiment samples. The candidates are an external data pin, a free-running oscillator signal, and that oscillator divided by eight or by sixteen. The divided versions come from a small counter that is clocked by the oscillator itself. Its outputs toggle more slowly, but they remain unrelated in phase to the system clock. A second output carries a monitor copy of the chosen data, so that the stimulus can be observed outside the block.

The block also decides whether the oscillator may run. The oscillator runs only when the tile is enabled, when an internal source is chosen and when the frequency code is not zero. When it does run, the block names the ring length to use through a one-hot tap select. The ring itself is not part of this block. In simulation, the oscillator appears as an input that toggles.

Top module: `stim_source_top`

## Requirements
- R1: With source code 2'b00 the data output equals `ext_data`.
- R2: With source code 2'b01 the data output equals `osc_in` while `osc_run` is high.
- R3: With source code 2'b10 the data output is bit 2 of a counter of `osc_in` rising edges. It goes high after the 4th edge and low after the 8th edge, which divides the oscillator by 8.
- R4: With source code 2'b11 the data output is bit 3 of the same counter. It goes high after the 8th edge and low after the 16th edge, which divides the oscillator by 16.
- R5: Source code 2'b00 forces `osc_run` low.
- R6: Frequency code 3'b000 forces `osc_run` low.
- R7: `tile_en` low forces `osc_run` low, whatever the other controls are.
- R8: `stim_mon` always equals `stim_out`.
- R9: While `osc_run` is low, the edge counter is held at zero. After re-enabling, the division therefore restarts from phase zero.
- R10: While `osc_run` is low and an internal source is selected, `stim_out` is 0.
- R11: `ring_tap` is one-hot, with bit (frequency code − 1) set, while `osc_run` is high. It is all zero while `osc_run` is low.
- R12: `osc_run` and `ring_tap` are registered on `clk`. They follow the controls one clock edge later, and a synchronous `rst` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Free-running oscillator signal (modelled) |
| ext_data | input | 1 | External data for bypass |
| src_sel | input | 2 | Source code: 00 external, 01 raw, 10 /8, 11 /16 |
| freq_code | input | 3 | Ring length code, 0 = off |
| tile_en | input | 1 | Tile enable |
| osc_run | output | 1 | Oscillator enable |
| ring_tap | output | 7 | One-hot ring length select |
| stim_out | output | 1 | Selected stimulus data |
| stim_mon | output | 1 | Monitor copy of the stimulus |

## Verification
On every clock cycle, the assertions check the three conditions that stop the oscillator (R5, R6, R7). They also check that the tap select is one-hot or empty (R11), that the divider is held at zero while stopped (R9), and that an internal source reads 0 while stopped (R10). Only the bench scenarios can show the division ratios (R3, R4), the restart from phase zero after re-enable, the raw pass-through, and the mirroring of the monitor (R8). To do this, the bench counts oscillator edges against a model of its own.

// File: rtl/stim_source_pkg.sv
package stim_source_pkg;

    parameter int FREQ_W   = 3;
    parameter int TAP_N    = (1 << FREQ_W) - 1;
    parameter int SRC_W    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT   = 2'b00,
        SRC_RAW   = 2'b01,
        SRC_DIV8  = 2'b10,
        SRC_DIV16 = 2'b11
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [FREQ_W-1:0] freq;
        logic              tile_en;
    } stim_ctrl_t;

    function automatic logic run_allowed(stim_ctrl_t c);
        return c.tile_en && (c.src != SRC_EXT) && (c.freq != '0);
    endfunction

endpackage

// File: rtl/osc_gate.sv
module osc_gate
    import stim_source_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stim_ctrl_t       ctrl,
    output logic             run,
    output logic [TAP_N-1:0] tap
);

    logic             run_d;
    logic [TAP_N-1:0] tap_d;

    assign run_d = run_allowed(ctrl);

    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        assign tap_d[i] = run_d && (ctrl.freq == FREQ_W'(i + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            tap <= '0;
        end else begin
            run <= run_d;
            tap <= tap_d;
        end
    end

    // R7: a low tile enable stops the oscillator on the next edge
    assert_tile_off_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.tile_en |=> !run);

    // R5: choosing the external bypass stops the oscillator
    assert_bypass_off_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src == SRC_EXT) |=> !run);

    // R6: frequency code zero stops the oscillator
    assert_freq_zero_off_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.freq == '0) |=> !run);

    // R11: at most one tap, and none while stopped
    assert_tap_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tap) && (run || tap == '0));

endmodule

// File: rtl/osc_prescaler.sv
module osc_prescaler #(
    parameter int LO_BIT = 2,
    parameter int HI_BIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    input  logic run,
    output logic div_lo,
    output logic div_hi
);

    localparam int CNT_W = HI_BIT + 1;

    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge osc_in or negedge run) begin
        if (!run) begin
            edge_cnt <= '0;
        end else begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign div_lo = edge_cnt[LO_BIT];
    assign div_hi = edge_cnt[HI_BIT];

    // R9: divided outputs are at zero whenever the oscillator is stopped
    assert_div_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!div_lo && !div_hi));

endmodule

// File: rtl/stim_mux.sv
module stim_mux
    import stim_source_pkg::*;
(
    input  src_e src,
    input  logic ext_data,
    input  logic osc_in,
    input  logic run,
    input  logic div_lo,
    input  logic div_hi,
    output logic data
);

    always_comb begin
        unique case (src)
            SRC_EXT:   data = ext_data;
            SRC_RAW:   data = osc_in && run;
            SRC_DIV8:  data = div_lo;
            SRC_DIV16: data = div_hi;
            default:   data = 1'b0;
        endcase
    end

endmodule

// File: rtl/stim_source_top.sv
module stim_source_top
    import stim_source_pkg::*;
#(
    parameter int LO_BIT = 2,
    parameter int HI_BIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_in,
    input  logic             ext_data,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [FREQ_W-1:0] freq_code,
    input  logic             tile_en,
    output logic             osc_run,
    output logic [TAP_N-1:0] ring_tap,
    output logic             stim_out,
    output logic             stim_mon
);

    stim_ctrl_t ctrl;
    logic       div_lo;
    logic       div_hi;
    logic       sel_data;

    assign ctrl.src     = src_e'(src_sel);
    assign ctrl.freq    = freq_code;
    assign ctrl.tile_en = tile_en;

    osc_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .run  (osc_run),
        .tap  (ring_tap)
    );

    osc_prescaler #(.LO_BIT(LO_BIT), .HI_BIT(HI_BIT)) u_div (
        .clk    (clk),
        .rst    (rst),
        .osc_in (osc_in),
        .run    (osc_run),
        .div_lo (div_lo),
        .div_hi (div_hi)
    );

    stim_mux u_mux (
        .src      (ctrl.src),
        .ext_data (ext_data),
        .osc_in   (osc_in),
        .run      (osc_run),
        .div_lo   (div_lo),
        .div_hi   (div_hi),
        .data     (sel_data)
    );

    assign stim_out = sel_data;
    assign stim_mon = sel_data;

    // R10: an internal source reads 0 while the oscillator is stopped
    assert_stopped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!osc_run && src_sel != 2'b00) |-> !stim_out);

endmodule

// File: tb/test_stim_source_top.sv
module test_stim_source_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_in = 1'b0;
    logic       ext_data = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [2:0] freq_code = 3'd0;
    logic       tile_en = 1'b0;
    logic       osc_run;
    logic [6:0] ring_tap;
    logic       stim_out;
    logic       stim_mon;

    stim_source_top i_stim_source_top (
        .clk(clk), .rst(rst), .osc_in(osc_in), .ext_data(ext_data),
        .src_sel(src_sel), .freq_code(freq_code), .tile_en(tile_en),
        .osc_run(osc_run), .ring_tap(ring_tap),
        .stim_out(stim_out), .stim_mon(stim_mon)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic       stim;
        logic       run;
        logic [6:0] tap;
        string      tag;
    } exp_t;

    exp_t   sb_q[$];
    event   sample_ev;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 0;
    logic   run_m = 1'b0;
    int     cnt_m = 0;

    always @(posedge osc_in) begin
        if (run_m) cnt_m = (cnt_m + 1) % 16;
    end

    task automatic fail(string tag, string what, int act, int exp);
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    endtask

    always @(sample_ev) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (stim_out !== e.stim) fail(e.tag, "stim_out", int'(stim_out), int'(e.stim));
        if (stim_mon !== e.stim) fail({e.tag, "/R8"}, "stim_mon", int'(stim_mon), int'(e.stim));
        if (osc_run !== e.run)   fail(e.tag, "osc_run", int'(osc_run), int'(e.run));
        if (ring_tap !== e.tap)  fail(e.tag, "ring_tap", int'(ring_tap), int'(e.tap));
    end

    task automatic apply(logic r, logic [1:0] s, logic [2:0] f, logic t,
                         logic x, string tag);
        exp_t e;
        @(negedge clk);
        rst = r; src_sel = s; freq_code = f; tile_en = t; ext_data = x;
        @(posedge clk);
        #1;
        run_m = !r && t && (s != 2'b00) && (f != 3'd0);
        if (!run_m) cnt_m = 0;
        case (s)
            2'b00: e.stim = x;
            2'b01: e.stim = osc_in && run_m;
            2'b10: e.stim = cnt_m[2];
            default: e.stim = cnt_m[3];
        endcase
        e.run = run_m;
        e.tap = run_m ? 7'(1 << (f - 3'd1)) : 7'd0;
        e.tag = tag;
        sb_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 osc_in = 1'b1;
            #1 osc_in = 1'b0;
        end
    endtask

    task automatic set_osc(logic v);
        @(negedge clk);
        #1 osc_in = v;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        // reset state (R12): run and tap cleared, bypass passes ext
        apply(1, 2'b00, 3'd3, 1, 1, "R12 reset");
        apply(1, 2'b01, 3'd3, 1, 0, "R12 reset");
        // R1 and R5: bypass routes ext and keeps the oscillator off
        apply(0, 2'b00, 3'd5, 1, 1, "R1/R5 ext=1");
        apply(0, 2'b00, 3'd5, 1, 0, "R1/R5 ext=0");
        pulses(3);
        apply(0, 2'b00, 3'd5, 1, 1, "R1/R5 pulses ignored");
        // R2: raw oscillator
        apply(0, 2'b01, 3'd3, 1, 0, "R2 raw low R11");
        set_osc(1);
        apply(0, 2'b01, 3'd3, 1, 0, "R2 raw high");
        set_osc(0);
        apply(0, 2'b01, 3'd3, 1, 0, "R2 raw back low");
        // R3: divide by 8 (count carries over from raw edge)
        apply(0, 2'b10, 3'd1, 1, 0, "R3 div8 start");
        pulses(2);
        apply(0, 2'b10, 3'd1, 1, 0, "R3 div8 after 3");
        pulses(1);
        apply(0, 2'b10, 3'd1, 1, 0, "R3 div8 after 4");
        pulses(3);
        apply(0, 2'b10, 3'd1, 1, 0, "R3 div8 after 7");
        pulses(1);
        apply(0, 2'b10, 3'd1, 1, 0, "R3 div8 after 8");
        // R4: divide by 16
        apply(0, 2'b11, 3'd7, 1, 0, "R4 div16 at 8");
        pulses(7);
        apply(0, 2'b11, 3'd7, 1, 0, "R4 div16 at 15");
        pulses(1);
        apply(0, 2'b11, 3'd7, 1, 0, "R4 div16 wrap");
        pulses(5);
        // R7, R9, R10: tile disable stops and clears
        apply(0, 2'b10, 3'd7, 0, 1, "R7/R9/R10 tile off");
        pulses(6);
        apply(0, 2'b11, 3'd7, 0, 1, "R9/R10 held at zero");
        apply(0, 2'b01, 3'd7, 0, 1, "R10 raw stopped");
        set_osc(1);
        apply(0, 2'b01, 3'd7, 0, 1, "R10 raw stopped osc high");
        set_osc(0);
        // R9: restart from phase zero
        apply(0, 2'b10, 3'd2, 1, 0, "R9 restart");
        pulses(3);
        apply(0, 2'b10, 3'd2, 1, 0, "R9 restart after 3");
        pulses(1);
        apply(0, 2'b10, 3'd2, 1, 0, "R9 restart after 4");
        // R6: frequency code zero
        apply(0, 2'b11, 3'd0, 1, 0, "R6 freq zero");
        pulses(9);
        apply(0, 2'b11, 3'd0, 1, 0, "R6 freq zero pulses");
        // R11: every tap code
        for (int f = 1; f < 8; f++) begin
            apply(0, 2'b01, 3'(f), 1, 0, "R11 tap");
        end
        // R12: reset while running clears run
        apply(1, 2'b10, 3'd4, 1, 0, "R12 reset while running");
        apply(0, 2'b10, 3'd4, 1, 0, "R12 resume");
        #20;
        summary();
    end

endmodule